// File: doc/BRIEF.md
# Digital Potentiometer Wiper and Nonvolatile Setting Controller

This block keeps the tap setting of a 64-step digital potentiometer. It holds a volatile wiper code, an emulated nonvolatile copy of that code, a write-protect flag and two factory tolerance bytes that cannot be written. A serial front end, which is outside this block, decodes bus traffic into one-cycle command strobes. Each strobe carries a 3-bit opcode, a 5-bit register address, a data byte and a flag that says whether a data byte came with it. A strobe without a data byte only moves the readback pointer. The block drives the wiper code to the resistor ladder and returns the register selected by the pointer on `rd_data`.

Coming out of reset, the wiper first sits at midscale. A timed restore then copies the nonvolatile word into it. A store command and a restore command each occupy the block for a duration set by a parameter, counted in clock cycles. A completed restore command leaves the block in a high-current read state. That state lasts until a NOP command arrives.

Top module: `wiper_nv_ctrl`

## Requirements
- R1: While reset is held, `wiper` is 0x20, `busy` is 1, `low_pwr` is 1, the write-protect flag is 0 and the pointer selects the wiper register.
- R2: After reset is released, `busy` stays high for T_RESTORE cycles. At the end of that window `wiper` takes the nonvolatile word, whose reset value is NV_INIT (midscale by default). `low_pwr` stays 1 through this power-up restore.
- R3: An accepted opcode 000 command with a data byte loads `cmd_data[5:0]` into `wiper` on the same edge. Data bits 7..6 are ignored.
- R4: An accepted opcode 001 command with a data byte, at any address other than 11110 or 11111, writes `cmd_data[5:0]` into the nonvolatile word, provided write protect is clear.
- R5: Opcode 010 with a data byte sets write protect to `cmd_data[0]`. While write protect is 1, nonvolatile writes and store commands are refused, and wiper writes are still accepted.
- R6: Opcode 110 (store) raises `busy` for T_STORE cycles. At the end of that window the wiper code is copied into the nonvolatile word.
- R7: Opcode 101 (restore) raises `busy` for T_RESTORE cycles. At the end of that window the nonvolatile word is copied into `wiper` and `low_pwr` drops to 0. `low_pwr` returns to 1 only when an opcode 100 (NOP) command is accepted.
- R8: A command strobe that arrives while `busy` is high is ignored entirely.
- R9: Opcode 001 at address 11110 reads TOL_INT, a sign-magnitude byte in which bit 7 = 1 means negative and bits 6..0 are integer percent. Opcode 001 at address 11111 reads TOL_FRAC, a fraction with bit 7 weighted 2^-1 down to bit 0 weighted 2^-8. Writes to either address are ignored.
- R10: The pointer is set by every accepted command with opcode 000, 001 or 010, with or without a data byte. `rd_data` then shows, zero-extended, the wiper code for 000, the nonvolatile word or a tolerance byte for 001, and the write-protect flag in bit 0 for 010.
- R11: Opcodes 011 and 111 have no effect on any output or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, acts as power-on |
| cmd_valid | input | 1 | One-cycle decoded command strobe |
| cmd_wr | input | 1 | Command carries a data byte |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 5 | Register address within the opcode |
| cmd_data | input | 8 | Data byte |
| wiper | output | 6 | Wiper tap code to the ladder |
| rd_data | output | 8 | Register selected by the pointer |
| busy | output | 1 | Store or restore in progress |
| low_pwr | output | 1 | 1 = idle low-current state, 0 = post-restore read state |

## Verification
The assertions check on every cycle the following rules:
- the wiper holds still while a timed operation runs;
- a wiper write lands in the next cycle;
- write-protect and tolerance readback follow their commands;
- `busy` rises only after a store or restore command;
- the high-current state begins only when a restore finishes and ends at a NOP.

Other behaviour needs the bench's command sequences to show:
- the exact length of the store and restore windows;
- a stored value surviving and coming back through a restore;
- refused writes under write protect;
- commands ignored while busy;
- the power-up restore of a non-midscale word.

// File: rtl/wnv_pkg.sv
package wnv_pkg;
   typedef enum logic [2:0] {
      OP_WIPER   = 3'b000,
      OP_NVM     = 3'b001,
      OP_WPROT   = 3'b010,
      OP_RSV3    = 3'b011,
      OP_NOP     = 3'b100,
      OP_RESTORE = 3'b101,
      OP_STORE   = 3'b110,
      OP_RSV7    = 3'b111
   } op_e;

   typedef enum logic [1:0] {
      JOB_NONE,
      JOB_PWRUP,
      JOB_RESTORE,
      JOB_STORE
   } job_e;

   typedef enum logic [2:0] {
      SEL_WIPER,
      SEL_NV,
      SEL_TINT,
      SEL_TFRAC,
      SEL_WP
   } sel_e;
endpackage

// File: rtl/wnv_timer.sv
module wnv_timer #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= CNT_W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/wnv_regs.sv
module wnv_regs
   import wnv_pkg::*;
#(
   parameter int          WIPER_W  = 6,
   parameter int          DATA_W   = 8,
   parameter logic [WIPER_W-1:0] NV_INIT  = 6'h20,
   parameter logic [DATA_W-1:0]  TOL_INT  = 8'h00,
   parameter logic [DATA_W-1:0]  TOL_FRAC = 8'h00
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_wiper,
   input  logic               wr_nv,
   input  logic               wr_wp,
   input  logic [WIPER_W-1:0] din,
   input  logic               wp_bit,
   input  logic               ptr_load,
   input  sel_e               ptr_sel,
   input  logic               nv_to_wiper,
   input  logic               wiper_to_nv,
   output logic [WIPER_W-1:0] wiper,
   output logic               wp,
   output logic [DATA_W-1:0]  rd_data
);
   localparam logic [WIPER_W-1:0] MIDSCALE = WIPER_W'(1) << (WIPER_W - 1);

   logic [WIPER_W-1:0] wiper_q, nv_q;
   logic [DATA_W-1:0]  tint_q, tfrac_q;
   logic               wp_q;
   sel_e               sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wiper_q <= MIDSCALE;
         nv_q    <= NV_INIT;
         wp_q    <= 1'b0;
         tint_q  <= TOL_INT;
         tfrac_q <= TOL_FRAC;
         sel_q   <= SEL_WIPER;
      end else begin
         if (nv_to_wiper)   wiper_q <= nv_q;
         else if (wr_wiper) wiper_q <= din;
         if (wiper_to_nv)   nv_q    <= wiper_q;
         else if (wr_nv)    nv_q    <= din;
         if (wr_wp)         wp_q    <= wp_bit;
         if (ptr_load)      sel_q   <= ptr_sel;
      end
   end

   always_comb begin
      unique case (sel_q)
         SEL_NV:    rd_data = DATA_W'(nv_q);
         SEL_TINT:  rd_data = tint_q;
         SEL_TFRAC: rd_data = tfrac_q;
         SEL_WP:    rd_data = DATA_W'(wp_q);
         default:   rd_data = DATA_W'(wiper_q);
      endcase
   end

   assign wiper = wiper_q;
   assign wp    = wp_q;
endmodule

// File: rtl/wiper_nv_ctrl.sv
module wiper_nv_ctrl
   import wnv_pkg::*;
#(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 8,
   parameter int WIPER_W   = 6,
   parameter int T_STORE   = 2600000,
   parameter int T_RESTORE = 30000,
   parameter logic [WIPER_W-1:0] NV_INIT  = 6'h20,
   parameter logic [DATA_W-1:0]  TOL_INT  = 8'h85,
   parameter logic [DATA_W-1:0]  TOL_FRAC = 8'h40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic               cmd_wr,
   input  logic [2:0]         cmd_op,
   input  logic [ADDR_W-1:0]  cmd_addr,
   input  logic [DATA_W-1:0]  cmd_data,
   output logic [WIPER_W-1:0] wiper,
   output logic [DATA_W-1:0]  rd_data,
   output logic               busy,
   output logic               low_pwr
);
   localparam int T_MAX = (T_STORE > T_RESTORE) ? T_STORE : T_RESTORE;
   localparam int CNT_W = $clog2(T_MAX + 1);
   localparam logic [CNT_W-1:0] LD_STORE   = CNT_W'(T_STORE - 1);
   localparam logic [CNT_W-1:0] LD_RESTORE = CNT_W'(T_RESTORE - 1);

   generate
      if (WIPER_W < 1 || WIPER_W > DATA_W) begin : g_bad_width
         $error("wiper_nv_ctrl: WIPER_W must lie in 1..DATA_W");
      end
      if (T_STORE < 1 || T_RESTORE < 1) begin : g_bad_time
         $error("wiper_nv_ctrl: store and restore times must be at least one cycle");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("wiper_nv_ctrl: ADDR_W must be at least 2");
      end
   endgenerate

   job_e job_q;
   logic zero, accept, finish, tol_addr, wp, start_store, start_restore;
   sel_e ptr_sel;
   logic unused_hi;

   assign unused_hi = ^cmd_data;
   assign busy     = (job_q != JOB_NONE);
   assign accept   = cmd_valid && !busy;
   assign finish   = busy && zero;
   assign tol_addr = (cmd_addr[ADDR_W-1:1] == '1);

   assign start_store   = accept && (cmd_op == OP_STORE) && !wp;
   assign start_restore = accept && (cmd_op == OP_RESTORE);

   always_comb begin
      if (cmd_op == OP_WIPER)      ptr_sel = SEL_WIPER;
      else if (cmd_op == OP_WPROT) ptr_sel = SEL_WP;
      else if (!tol_addr)          ptr_sel = SEL_NV;
      else if (cmd_addr[0])        ptr_sel = SEL_TFRAC;
      else                         ptr_sel = SEL_TINT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         job_q   <= JOB_PWRUP;
         low_pwr <= 1'b1;
      end else begin
         if (finish)             job_q <= JOB_NONE;
         else if (start_restore) job_q <= JOB_RESTORE;
         else if (start_store)   job_q <= JOB_STORE;
         if (finish && job_q == JOB_RESTORE)   low_pwr <= 1'b0;
         else if (accept && cmd_op == OP_NOP)  low_pwr <= 1'b1;
      end
   end

   wnv_timer #(
      .CNT_W  (CNT_W),
      .RST_VAL(T_RESTORE - 1)
   ) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start_store || start_restore),
      .load_val(start_store ? LD_STORE : LD_RESTORE),
      .zero    (zero)
   );

   wnv_regs #(
      .WIPER_W (WIPER_W),
      .DATA_W  (DATA_W),
      .NV_INIT (NV_INIT),
      .TOL_INT (TOL_INT),
      .TOL_FRAC(TOL_FRAC)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_wiper   (accept && cmd_wr && cmd_op == OP_WIPER),
      .wr_nv      (accept && cmd_wr && cmd_op == OP_NVM && !wp && !tol_addr),
      .wr_wp      (accept && cmd_wr && cmd_op == OP_WPROT),
      .din        (cmd_data[WIPER_W-1:0]),
      .wp_bit     (cmd_data[0]),
      .ptr_load   (accept && (cmd_op == OP_WIPER || cmd_op == OP_NVM || cmd_op == OP_WPROT)),
      .ptr_sel    (ptr_sel),
      .nv_to_wiper(finish && (job_q == JOB_PWRUP || job_q == JOB_RESTORE)),
      .wiper_to_nv(finish && job_q == JOB_STORE),
      .wiper      (wiper),
      .wp         (wp),
      .rd_data    (rd_data)
   );
endmodule

// File: rtl/wnv_chk.sv
module wnv_chk #(
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 8,
   parameter int WIPER_W = 6,
   parameter logic [DATA_W-1:0] TOL_INT = 8'h85
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_valid,
   input logic               cmd_wr,
   input logic [2:0]         cmd_op,
   input logic [ADDR_W-1:0]  cmd_addr,
   input logic [DATA_W-1:0]  cmd_data,
   input logic [WIPER_W-1:0] wiper,
   input logic [DATA_W-1:0]  rd_data,
   input logic               busy,
   input logic               low_pwr
);
   logic acc;
   assign acc = cmd_valid && !busy;

   AST_WIPER_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy) |-> $stable(wiper)); // R8

   AST_WIPER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_wr && cmd_op == 3'b000) |=> (wiper == $past(cmd_data[WIPER_W-1:0]))); // R3

   AST_WP_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_wr && cmd_op == 3'b010) |=> (rd_data == DATA_W'($past(cmd_data[0])))); // R5

   AST_TOL_INT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !cmd_wr && cmd_op == 3'b001 && cmd_addr == {{(ADDR_W-1){1'b1}}, 1'b0})
      |=> (rd_data == TOL_INT)); // R9

   AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(cmd_valid) && ($past(cmd_op) == 3'b101 || $past(cmd_op) == 3'b110))); // R6

   AST_HIPWR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(low_pwr) |-> $fell(busy)); // R7

   AST_NOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == 3'b100) |=> low_pwr); // R7
endmodule

bind wiper_nv_ctrl wnv_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .WIPER_W(WIPER_W),
   .TOL_INT(TOL_INT)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .cmd_wr   (cmd_wr),
   .cmd_op   (cmd_op),
   .cmd_addr (cmd_addr),
   .cmd_data (cmd_data),
   .wiper    (wiper),
   .rd_data  (rd_data),
   .busy     (busy),
   .low_pwr  (low_pwr)
);

// File: tb/wiper_nv_ctrl_tb_top.sv
`timescale 1ns/1ps
module wiper_nv_ctrl_tb_top;
   localparam int T_ST = 40;
   localparam int T_RS = 12;
   localparam logic [5:0] NVI = 6'h2B;
   localparam logic [7:0] TINT = 8'h85;
   localparam logic [7:0] TFRAC = 8'h40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [2:0] cmd_op = 3'b000;
   logic [4:0] cmd_addr = 5'd0;
   logic [7:0] cmd_data = 8'd0;
   logic [5:0] wiper;
   logic [7:0] rd_data;
   logic       busy, low_pwr;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wiper_nv_ctrl #(
      .T_STORE(T_ST), .T_RESTORE(T_RS), .NV_INIT(NVI),
      .TOL_INT(TINT), .TOL_FRAC(TFRAC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
      .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
      .wiper(wiper), .rd_data(rd_data), .busy(busy), .low_pwr(low_pwr)
   );

   // reference model
   logic [5:0] m_wiper, m_nv;
   logic       m_wp, m_lp, m_busy;
   logic [2:0] m_pop;
   logic [4:0] m_paddr;
   int         m_cnt;
   int         m_job; // 1 power-up, 2 restore, 3 store

   function automatic logic [7:0] exp_rd();
      case (m_pop)
         3'b001:  exp_rd = (m_paddr == 5'd30) ? TINT : (m_paddr == 5'd31) ? TFRAC : {2'b00, m_nv};
         3'b010:  exp_rd = {7'd0, m_wp};
         default: exp_rd = {2'b00, m_wiper};
      endcase
   endfunction

   task automatic model_reset();
      m_wiper = 6'h20; m_nv = NVI; m_wp = 1'b0; m_lp = 1'b1; m_busy = 1'b1;
      m_pop = 3'b000; m_paddr = 5'd0; m_cnt = T_RS - 1; m_job = 1;
   endtask

   task automatic model_edge();
      if (m_busy) begin
         if (m_cnt == 0) begin
            m_busy = 1'b0;
            if (m_job == 3) m_nv = m_wiper;
            else begin
               m_wiper = m_nv;
               if (m_job == 2) m_lp = 1'b0;
            end
         end else m_cnt--;
      end else if (cmd_valid) begin
         if (cmd_op inside {3'b000, 3'b001, 3'b010}) begin
            m_pop = cmd_op; m_paddr = cmd_addr;
         end
         case (cmd_op)
            3'b000: if (cmd_wr) m_wiper = cmd_data[5:0];
            3'b001: if (cmd_wr && !m_wp && cmd_addr[4:1] != 4'b1111) m_nv = cmd_data[5:0];
            3'b010: if (cmd_wr) m_wp = cmd_data[0];
            3'b100: m_lp = 1'b1;
            3'b101: begin m_busy = 1'b1; m_cnt = T_RS - 1; m_job = 2; end
            3'b110: if (!m_wp) begin m_busy = 1'b1; m_cnt = T_ST - 1; m_job = 3; end
            default: ;
         endcase
      end
   endtask

   task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare(string tag);
      check(tag, "wiper",   {2'b00, wiper}, {2'b00, m_wiper});
      check(tag, "rd_data", rd_data, exp_rd());
      check(tag, "busy",    {7'd0, busy}, {7'd0, m_busy});
      check(tag, "low_pwr", {7'd0, low_pwr}, {7'd0, m_lp});
   endtask

   task automatic step(string tag);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      cmd_valid = 1'b0;
      compare(tag);
   endtask

   task automatic issue(logic [2:0] op, logic [4:0] a, logic [7:0] d, logic w, string tag);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_wr = w;
      step(tag);
   endtask

   task automatic idle(int n, string tag);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(10 * 200000);
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
   end

   initial begin
      process::self().srandom(32'd1337);
      model_reset();
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      // R2: midscale during power-up restore, then NV_INIT
      idle(T_RS + 2, "R2");
      // R3: upper data bits ignored
      issue(3'b000, 5'd0, 8'hFF, 1'b1, "R3");
      issue(3'b000, 5'd0, 8'hC5, 1'b1, "R3");
      // R4: nonvolatile write and read pointer
      issue(3'b001, 5'd0, 8'h11, 1'b1, "R4");
      issue(3'b001, 5'd3, 8'h00, 1'b0, "R10");
      // R9: tolerance reads and ignored writes
      issue(3'b001, 5'd30, 8'h00, 1'b0, "R9");
      issue(3'b001, 5'd31, 8'h00, 1'b0, "R9");
      issue(3'b001, 5'd31, 8'h3C, 1'b1, "R9");
      issue(3'b001, 5'd0, 8'h00, 1'b0, "R9");
      // R5: write protect
      issue(3'b010, 5'd0, 8'h01, 1'b1, "R5");
      issue(3'b001, 5'd0, 8'h2E, 1'b1, "R5");
      issue(3'b110, 5'd0, 8'h00, 1'b0, "R5");
      idle(2, "R5");
      issue(3'b000, 5'd0, 8'h07, 1'b1, "R5");
      issue(3'b010, 5'd0, 8'hFE, 1'b1, "R5");
      // R6 + R8: store, with commands ignored while busy
      issue(3'b110, 5'd0, 8'h00, 1'b0, "R6");
      issue(3'b000, 5'd0, 8'h3F, 1'b1, "R8");
      issue(3'b001, 5'd0, 8'h01, 1'b1, "R8");
      idle(T_ST, "R6");
      issue(3'b001, 5'd0, 8'h00, 1'b0, "R6");
      // R7: restore, high-current state until NOP
      issue(3'b000, 5'd0, 8'h30, 1'b1, "R7");
      issue(3'b101, 5'd0, 8'h00, 1'b0, "R7");
      issue(3'b100, 5'd0, 8'h00, 1'b0, "R8");
      idle(T_RS + 3, "R7");
      issue(3'b011, 5'd0, 8'h3A, 1'b1, "R11");
      issue(3'b111, 5'd30, 8'h15, 1'b1, "R11");
      issue(3'b100, 5'd0, 8'h00, 1'b0, "R7");
      // random phase
      for (int k = 0; k < 400; k++) begin
         logic [2:0] op;
         logic [4:0] a;
         int pick;
         pick = $urandom_range(0, 19);
         op = (pick < 5) ? 3'b000 : (pick < 10) ? 3'b001 : (pick < 13) ? 3'b010 :
              (pick < 15) ? 3'b100 : (pick == 15) ? 3'b101 : (pick == 16) ? 3'b110 :
              (pick == 17) ? 3'b011 : (pick == 18) ? 3'b111 : 3'b000;
         pick = $urandom_range(0, 3);
         a = (pick == 0) ? 5'd30 : (pick == 1) ? 5'd31 : 5'($urandom_range(0, 29));
         if ($urandom_range(0, 3) == 0) idle(1, "R10");
         issue(op, a, 8'($urandom), 1'($urandom), "R10");
      end
      idle(T_ST + 2, "R8");
      finish_run();
   end
endmodule